// File: doc/BRIEF.md
# Shadow-Buffered PWM Channel

This block is one pulse-width modulation channel driven through four word-wide registers on a simple synchronous bus. Software writes a period and a duty count, both in cycles of the block clock, and a control word. The control word holds the run bits, the two output levels and a lock bit. Period, duty and both output levels are first written to a shadow set. The counter and the output comparator only ever use a separate active set. The active set is loaded from the shadow set in one step. This happens only at the start of a period and only while the lock bit is clear. Software can therefore set the lock, rewrite everything, and release the lock, and the waveform changes cleanly at the next period start.

The counter is left-aligned. It runs from zero to period minus one and wraps. The output is at the active level while the counter is below the duty count and at the opposite level for the rest of the period. The channel has two states. **IDLE** holds the counter at zero, drives the idle level, and copies the shadow set into the active set on every unlocked cycle. **RUN** counts. The transitions are:
- **IDLE→RUN (start):** taken when the control word holds a valid run setting. The counter begins at zero, and the copy made on that same edge supplies the first period.
- **RUN→RUN (wrap):** taken at the last count of a period. The counter returns to zero and the active set is reloaded if the lock is clear.
- **RUN→IDLE (stop):** taken as soon as the run setting is no longer valid.

Top module: `pwm_shadow_chan`

## Requirements
- R1: Byte addresses select the registers: 0x0 is the live counter, 0x4 the period shadow, 0x8 the duty shadow and 0xC the control word. Period and duty read back their shadow values, zero-extended. Control reads back bits 8:0 with bit 7 always zero. A write takes effect at the clock edge on which the write enable is high.
- R2: After the active-low synchronous reset, the control word reads 0x018, period and duty read 0, the counter reads 0 and the output is high.
- R3: The channel runs only when all four of these hold: control bit 0 (enable) is 1, bits 2:1 (mode) are 2'b01, bit 5 (alignment) is 0 and bit 8 (low-power off) is 1. Any other setting keeps it in IDLE.
- R4: In RUN with an active period P > 1, the counter reads 0, 1, …, P−1 and then 0 again, advancing once per clock.
- R5: In RUN the output is at the active level while counter < active duty, and at the inverse level otherwise. A duty of at least P keeps it active for the whole period, and a duty of 0 never makes it active.
- R6: Control bit 3 chooses the active level (1 = high) and bit 4 chooses the idle level (1 = high). The two are independent.
- R7: In IDLE the counter reads 0 and the output equals the committed idle level. With the lock clear, a new idle level reaches the output one clock after the control write.
- R8: While control bit 6 (lock) is set, writes to period, duty and the level bits leave the generated waveform unchanged.
- R9: After the lock is cleared, the new period, duty and both levels take effect together on the edge where the counter wraps to 0.
- R10: An unlocked write made during a period does not affect that period. It takes effect at the next wrap.
- R11: On IDLE→RUN with the lock clear, the shadow values are committed on the same edge and the counter starts at 0.
- R12: An active period of 0 or 1 keeps the counter at 0 in RUN. The output is then active exactly when duty > 0.
- R13: An access whose address bits 1:0 are not zero is ignored on write and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; counts are in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address of the register access |
| bus_we | input | 1 | Write enable, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | 1 | Modulated output |

## Verification
The embedded assertions check the following on every cycle:
- the counter stays below the active period and sits at zero in IDLE and for short periods;
- the active set cannot change while the lock is held or in the middle of a period;
- a start commits the shadow duty and zeroes the counter;
- shadow writes land and misaligned writes leave all state untouched.

Only the bench's scenarios show:
- the output waveform itself across a sweep of periods, duties and polarities;
- the rejection of each invalid run setting;
- the exact period edge at which a lock release or an unlocked mid-period rewrite becomes visible.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

    // Channel states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pwm_state_e;

    // Bus address width (byte addresses, word registers)
    localparam int ADDR_W = 4;

    // Register select values taken from address bits 3:2
    localparam logic [1:0] SEL_COUNT  = 2'd0;
    localparam logic [1:0] SEL_PERIOD = 2'd1;
    localparam logic [1:0] SEL_DUTY   = 2'd2;
    localparam logic [1:0] SEL_CTRL   = 2'd3;

    // Control word layout
    localparam int CTRL_W     = 9;
    localparam int CB_EN      = 0;
    localparam int CB_MODE_LO = 1;
    localparam int CB_MODE_HI = 2;
    localparam int CB_ACT_HI  = 3;
    localparam int CB_IDLE_HI = 4;
    localparam int CB_ALIGN   = 5;
    localparam int CB_LOCK    = 6;
    localparam int CB_LPOFF   = 8;

    localparam logic [1:0]        MODE_CONT  = 2'b01;
    localparam logic [CTRL_W-1:0] CTRL_MASK  = 9'h17F;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h018;

endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
    import pwm_shadow_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic [31:0]       rdata,
    output logic [CNT_W-1:0]  sh_period,
    output logic [CNT_W-1:0]  sh_duty,
    output logic              sh_act_hi,
    output logic              sh_idle_hi,
    output logic              run_ok,
    output logic              lock
);

    localparam int SEL_LSB = 2;

    logic [CTRL_W-1:0] ctrl_q;
    logic [1:0]        sel;
    logic              aligned;
    logic              wr_hit;
    logic              unused_wdata;

    assign sel          = addr[SEL_LSB+1:SEL_LSB];
    assign aligned      = (addr[SEL_LSB-1:0] == '0);
    assign wr_hit       = we && aligned;
    assign unused_wdata = ^wdata[31:CNT_W];

    // Shadow register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_period <= '0;
            sh_duty   <= '0;
            ctrl_q    <= CTRL_RESET;
        end else if (wr_hit) begin
            unique case (sel)
                SEL_PERIOD: sh_period <= wdata[CNT_W-1:0];
                SEL_DUTY:   sh_duty   <= wdata[CNT_W-1:0];
                SEL_CTRL:   ctrl_q    <= wdata[CTRL_W-1:0] & CTRL_MASK;
                default:    ;
            endcase
        end
    end

    // Control decode
    assign sh_act_hi  = ctrl_q[CB_ACT_HI];
    assign sh_idle_hi = ctrl_q[CB_IDLE_HI];
    assign lock       = ctrl_q[CB_LOCK];
    assign run_ok     = ctrl_q[CB_EN]
                     && (ctrl_q[CB_MODE_HI:CB_MODE_LO] == MODE_CONT)
                     && !ctrl_q[CB_ALIGN]
                     && ctrl_q[CB_LPOFF];

    // Read mux
    always_comb begin
        rdata = '0;
        if (aligned) begin
            unique case (sel)
                SEL_COUNT:  rdata = 32'(live_cnt);
                SEL_PERIOD: rdata = 32'(sh_period);
                SEL_DUTY:   rdata = 32'(sh_duty);
                SEL_CTRL:   rdata = 32'(ctrl_q);
                default:    rdata = '0;
            endcase
        end
    end

    // R1: a period write lands in the shadow on the next cycle
    a_r1_period_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        (we && aligned && sel == SEL_PERIOD) |=> (sh_period == $past(wdata[CNT_W-1:0])));

    // R13: misaligned writes touch nothing
    a_r13_misaligned_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !aligned) |=> ($stable(ctrl_q) && $stable(sh_period) && $stable(sh_duty)));

endmodule

// File: rtl/pwm_shadow_core.sv
module pwm_shadow_core
    import pwm_shadow_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_ok,
    input  logic             lock,
    input  logic [CNT_W-1:0] sh_period,
    input  logic [CNT_W-1:0] sh_duty,
    input  logic             sh_act_hi,
    input  logic             sh_idle_hi,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_duty,
    output logic             act_act_hi,
    output logic             act_idle_hi
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    pwm_state_e       state, state_nx;
    logic [CNT_W-1:0] act_period;
    logic             last;
    logic             commit_ok;

    assign last      = (act_period <= ONE) || (cnt == act_period - ONE);
    assign commit_ok = !lock;
    assign running   = (state == ST_RUN);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (run_ok)  state_nx = ST_RUN;
            ST_RUN:  if (!run_ok) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Counter and active set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            act_period  <= '0;
            act_duty    <= '0;
            act_act_hi  <= 1'b1;
            act_idle_hi <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (commit_ok) begin
                        act_period  <= sh_period;
                        act_duty    <= sh_duty;
                        act_act_hi  <= sh_act_hi;
                        act_idle_hi <= sh_idle_hi;
                    end
                end
                ST_RUN: begin
                    if (!run_ok) begin
                        cnt <= '0;
                    end else if (last) begin
                        cnt <= '0;
                        if (commit_ok) begin
                            act_period  <= sh_period;
                            act_duty    <= sh_duty;
                            act_act_hi  <= sh_act_hi;
                            act_idle_hi <= sh_idle_hi;
                        end
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // R4: counter never reaches the active period
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && act_period > ONE) |-> (cnt < act_period));

    // R7: IDLE holds the counter at zero
    a_r7_idle_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (cnt == '0));

    // R12: short periods never leave zero
    a_r12_short_period: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && act_period <= ONE) |-> (cnt == '0));

    // R8: nothing commits while locked
    a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(act_period) && $stable(act_duty)
                  && $stable(act_act_hi) && $stable(act_idle_hi)));

    // R10: no commit in the middle of a period
    a_r10_no_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && run_ok && !last) |=> ($stable(act_period) && $stable(act_duty)
                  && $stable(act_act_hi) && $stable(act_idle_hi)));

    // R11: an unlocked start commits shadow duty and zeroes the counter
    a_r11_start_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && run_ok && !lock) |=>
            (state == ST_RUN && cnt == '0 && act_duty == $past(sh_duty)));

endmodule

// File: rtl/pwm_shadow_out.sv
module pwm_shadow_out #(
    parameter int CNT_W = 16
) (
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty,
    input  logic             act_hi,
    input  logic             idle_hi,
    output logic             pwm
);

    always_comb begin
        if (!running)        pwm = idle_hi;
        else if (cnt < duty) pwm = act_hi;
        else                 pwm = !act_hi;
    end

endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
    import pwm_shadow_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_o
);

    logic [CNT_W-1:0] sh_period, sh_duty, cnt, act_duty;
    logic             sh_act_hi, sh_idle_hi, run_ok, lock;
    logic             running, act_act_hi, act_idle_hi;

    pwm_shadow_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .live_cnt  (cnt),
        .rdata     (bus_rdata),
        .sh_period (sh_period),
        .sh_duty   (sh_duty),
        .sh_act_hi (sh_act_hi),
        .sh_idle_hi(sh_idle_hi),
        .run_ok    (run_ok),
        .lock      (lock)
    );

    pwm_shadow_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_ok     (run_ok),
        .lock       (lock),
        .sh_period  (sh_period),
        .sh_duty    (sh_duty),
        .sh_act_hi  (sh_act_hi),
        .sh_idle_hi (sh_idle_hi),
        .running    (running),
        .cnt        (cnt),
        .act_duty   (act_duty),
        .act_act_hi (act_act_hi),
        .act_idle_hi(act_idle_hi)
    );

    pwm_shadow_out #(.CNT_W(CNT_W)) u_out (
        .running(running),
        .cnt    (cnt),
        .duty   (act_duty),
        .act_hi (act_act_hi),
        .idle_hi(act_idle_hi),
        .pwm    (pwm_o)
    );

endmodule

// File: tb/test_pwm_shadow_chan.sv
module test_pwm_shadow_chan;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RUNB  = 32'h103;
    localparam logic [31:0] ACTH  = 32'h008;
    localparam logic [31:0] IDLEH = 32'h010;
    localparam logic [31:0] LOCKB = 32'h040;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        pwm_o;

    int n_vec = 0;
    int n_bad = 0;

    // Bench-side expectation of the register and channel state
    logic [8:0]  m_ctrl;
    logic [15:0] m_sp, m_sd, m_ap, m_ad, m_cnt;
    logic        m_run, m_aa, m_ai;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_shadow_chan i_pwm_shadow_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pwm_o    (pwm_o)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic m_commit();
        m_ap = m_sp;
        m_ad = m_sd;
        m_aa = m_ctrl[3];
        m_ai = m_ctrl[4];
    endtask

    task automatic m_edge(logic w, logic [3:0] a, logic [31:0] d);
        logic ok;
        logic cm;
        ok = m_ctrl[0] && (m_ctrl[2:1] == 2'b01) && !m_ctrl[5] && m_ctrl[8];
        cm = !m_ctrl[6];
        if (!m_run) begin
            m_cnt = '0;
            if (cm) m_commit();
            m_run = ok;
        end else if (!ok) begin
            m_run = 1'b0;
            m_cnt = '0;
        end else if (m_ap <= 16'd1 || m_cnt == m_ap - 16'd1) begin
            m_cnt = '0;
            if (cm) m_commit();
        end else begin
            m_cnt = m_cnt + 16'd1;
        end
        if (w && a[1:0] == 2'b00) begin
            case (a[3:2])
                2'd1: m_sp = d[15:0];
                2'd2: m_sd = d[15:0];
                2'd3: m_ctrl = d[8:0] & 9'h17F;
                default: ;
            endcase
        end
    endtask

    function automatic logic m_out();
        if (!m_run) return m_ai;
        return (m_cnt < m_ad) ? m_aa : !m_aa;
    endfunction

    // One clock: drive, edge, update expectation, check output
    task automatic cyc(logic w, logic [3:0] a, logic [31:0] d, string req);
        bus_we    = w;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        m_edge(w, a, d);
        @(negedge clk);
        bus_we = 1'b0;
        chk(req, 32'(pwm_o), 32'(m_out()));
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic run_idle(int n, string req);
        repeat (n) cyc(1'b0, 4'h0, 32'h0, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        m_ctrl = 9'h018; m_sp = '0; m_sd = '0; m_ap = '0; m_ad = '0;
        m_cnt = '0; m_run = 1'b0; m_aa = 1'b1; m_ai = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        chk("R2 output", 32'(pwm_o), 32'h1);
        rd(4'hC, 32'h018, "R2 ctrl");
        rd(4'h4, 32'h0, "R2 period");
        rd(4'h8, 32'h0, "R2 duty");
        rd(4'h0, 32'h0, "R2 counter");

        // R1: control readback masks bit 7
        cyc(1'b1, 4'hC, 32'h1FF, "R1");
        rd(4'hC, 32'h17F, "R1 ctrl mask");
        cyc(1'b1, 4'hC, IDLEH | ACTH, "R1");

        // R13: misaligned access
        cyc(1'b1, 4'h5, 32'h33, "R13");
        rd(4'h4, 32'h0, "R13 write ignored");
        rd(4'h5, 32'h0, "R13 read zero");

        // R3: every invalid run setting stays idle
        cyc(1'b1, 4'h4, 32'd4, "R3");
        cyc(1'b1, 4'h8, 32'd2, "R3");
        foreach (RUNB[k]) begin end
        for (int b = 0; b < 4; b++) begin
            logic [31:0] bad;
            case (b)
                0: bad = 32'h102;
                1: bad = 32'h105;
                2: bad = 32'h123;
                default: bad = 32'h003;
            endcase
            cyc(1'b1, 4'hC, bad | IDLEH | ACTH, "R3");
            run_idle(3, "R3");
            rd(4'h0, 32'h0, "R3 counter idle");
            chk("R3 output idle", 32'(pwm_o), 32'h1);
        end
        cyc(1'b1, 4'hC, RUNB | IDLEH | ACTH, "R3");
        run_idle(3, "R3");
        rd(4'h0, 32'd2, "R3 counter runs");

        // R7 / R6: idle level follows the control word
        cyc(1'b1, 4'hC, ACTH, "R7");
        run_idle(2, "R7");
        chk("R7 idle low", 32'(pwm_o), 32'h0);
        rd(4'h0, 32'h0, "R7 counter zero");
        cyc(1'b1, 4'hC, IDLEH, "R6");
        run_idle(2, "R6");
        chk("R6 idle high with active low", 32'(pwm_o), 32'h1);

        // Sweep: R4, R5, R6, R11, R12
        for (int p = 0; p < 6; p++) begin
            for (int d = 0; d < 7; d++) begin
                for (int pa = 0; pa < 2; pa++) begin
                    logic pab;
                    pab = pa[0];
                    cyc(1'b1, 4'h4, 32'(p), "R11");
                    cyc(1'b1, 4'h8, 32'(d), "R11");
                    cyc(1'b1, 4'hC, RUNB | IDLEH | (pab ? ACTH : 32'h0), "R11");
                    for (int i = 0; i < 2 * p + 3; i++) begin
                        int ce;
                        cyc(1'b0, 4'h0, 32'h0, "R5");
                        ce = (p > 1) ? (i % p) : 0;
                        rd(4'h0, 32'(ce), (p > 1) ? "R4 counter" : "R12 counter");
                        chk("R5 level", 32'(pwm_o), 32'((ce < d) ? pab : !pab));
                    end
                    cyc(1'b1, 4'hC, IDLEH, "R7");
                end
            end
        end

        // R8 / R9: lock, rewrite, release
        cyc(1'b1, 4'h4, 32'd4, "R8");
        cyc(1'b1, 4'h8, 32'd1, "R8");
        cyc(1'b1, 4'hC, RUNB | IDLEH | ACTH, "R8");
        run_idle(5, "R8");
        cyc(1'b1, 4'hC, RUNB | IDLEH | ACTH | LOCKB, "R8");
        cyc(1'b1, 4'h4, 32'd7, "R8");
        cyc(1'b1, 4'h8, 32'd6, "R8");
        cyc(1'b1, 4'hC, RUNB | IDLEH | LOCKB, "R8");
        for (int i = 0; i < 12; i++) begin
            cyc(1'b0, 4'h0, 32'h0, "R8");
            rd(4'h0, 32'(m_cnt), "R8 counter");
            chk("R8 old period kept", 32'(bus_rdata < 32'd4), 32'h1);
        end
        rd(4'h4, 32'd7, "R1 period shadow");
        rd(4'h8, 32'd6, "R1 duty shadow");
        cyc(1'b1, 4'hC, RUNB | IDLEH, "R9");
        for (int i = 0; i < 16; i++) begin
            cyc(1'b0, 4'h0, 32'h0, "R9");
            rd(4'h0, 32'(m_cnt), "R9 counter");
        end

        // R10: unlocked mid-period rewrite waits for the wrap
        cyc(1'b1, 4'h8, 32'd2, "R10");
        for (int i = 0; i < 10; i++) begin
            cyc(1'b0, 4'h0, 32'h0, "R10");
            rd(4'h0, 32'(m_cnt), "R10 counter");
        end

        cyc(1'b1, 4'hC, IDLEH, "R7");
        run_idle(2, "R7");
        chk("R7 final idle", 32'(pwm_o), 32'h1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule